// File: doc/BRIEF.md
# Interrupt Enable and Pending Unit

This block keeps the processor's global interrupt-enable flag. It also holds a latch that captures a device interrupt request until the processor services it. The control sequencer reads one combined output, `take_int`. It is high only when interrupts are enabled and a request is waiting, and it tells the sequencer to branch into its interrupt-entry microstates.

During entry the sequencer asserts `int_ack`. In that cycle the block places the requesting device's index, zero-extended, on a shared data bus. The value and a drive-enable are given as separate outputs. On the next rising edge the pending latch clears and the enable flag drops. The handler therefore starts with interrupts off. Microcode for the enable, disable and return instructions writes the flag through a load strobe with a data bit. A separate strobe puts the current flag value on the bus.

A short request pulse is never lost, even when the processor is busy or interrupts are off when the pulse occurs. The latch holds it until an acknowledge arrives.

Top module: `irq_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ien_flag` is 0, `take_int` is 0 and `bus_oe` is 0.
- R2: On a rising edge with `ien_load`=1 and `int_ack`=0, `ien_flag` takes the value of `ien_data`. With both `ien_load` and `int_ack` at 0, `ien_flag` keeps its value.
- R3: A request (`irq_req`=1 on a rising edge) stays pending across any number of cycles without `int_ack`, whatever the value of the enable flag. When the flag is later set, this shows as `take_int`=1.
- R4: `take_int` equals `ien_flag` AND the pending latch. It is 0 whenever the flag is 0.
- R5: A rising edge with `int_ack`=1 and `irq_req`=0 clears the pending latch.
- R6: A rising edge with `int_ack`=1 and `irq_req`=1 leaves the latch set, so the new request survives.
- R7: A rising edge with `int_ack`=1 clears `ien_flag`, even when `ien_load`=1 with `ien_data`=1 in the same cycle.
- R8: While `int_ack`=1, `bus_oe` is 1 and `bus_data` is 0x00000001, the device index zero-extended to 32 bits. This holds whatever the value of `ien_drive`.
- R9: While `ien_drive`=1 and `int_ack`=0, `bus_oe` is 1 and `bus_data` equals `ien_flag` in bit 0, with 0 in bits 31:1.
- R10: While `int_ack`=0 and `ien_drive`=0, `bus_oe` is 0 and `bus_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request from the timer device |
| ien_load | input | 1 | Write strobe for the enable flag |
| ien_drive | input | 1 | Put the enable flag on the bus |
| ien_data | input | 1 | Value written to the enable flag |
| int_ack | input | 1 | Interrupt acknowledge from the sequencer |
| take_int | output | 1 | Interrupt should be taken |
| ien_flag | output | 1 | Current interrupt-enable flag |
| bus_oe | output | 1 | Bus drive-enable |
| bus_data | output | 32 | Value offered to the bus |

## Verification
The bench builds the block with its defaults: a 32-bit bus, device index 1 in a 4-bit index field, and level-sampled requests. These values make the exact 32-bit acknowledge word checkable. Level sampling also makes the collision of a request with an acknowledge a single-cycle event that random stimulus reaches often. Random strobes with a biased request rate bring out long pending intervals while the flag is off, ack-over-load conflicts and bus-source priority. Directed sequences pin down each of these cases once.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

   // Source selected onto the shared bus.
   typedef enum logic [1:0] {
      BUS_IDLE  = 2'd0,
      BUS_INDEX = 2'd1,
      BUS_FLAG  = 2'd2
   } bus_src_e;

   // How the request input is sampled.
   localparam int REQ_LEVEL = 0;
   localparam int REQ_EDGE  = 1;

endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic data,
   input  logic ack,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (ack)    flag <= 1'b0;
      else if (load)   flag <= data;
   end

   assert_ack_clears_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !flag);

   assert_load_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ack) |=> (flag == $past(data)));

   assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !ack) |=> $stable(flag));

endmodule

// File: rtl/irq_pending_latch.sv
module irq_pending_latch #(
   parameter int REQ_MODE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic ack,
   output logic pend
);
   import irq_gate_pkg::*;

   logic set_evt;

   generate
      if (REQ_MODE == REQ_EDGE) begin : g_edge
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= req;
         end
         assign set_evt = req & ~req_q;
      end else begin : g_level
         assign set_evt = req;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= set_evt | (pend & ~ack);
   end

   initial begin
      assert (REQ_MODE == REQ_LEVEL || REQ_MODE == REQ_EDGE)
         else $error("irq_pending_latch: REQ_MODE must be level or edge");
   end

   assert_pend_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !ack) |=> pend);

   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !set_evt) |=> !pend);

   assert_collision_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> pend);

endmodule

// File: rtl/irq_bus_drive.sv
module irq_bus_drive #(
   parameter int BUS_W     = 32,
   parameter int IDX_W     = 4,
   parameter int DEV_INDEX = 1
) (
   input  logic             ack,
   input  logic             drive_flag,
   input  logic             flag,
   output logic             oe,
   output logic [BUS_W-1:0] data
);
   import irq_gate_pkg::*;

   localparam logic [IDX_W-1:0] IDX_VAL = IDX_W'(DEV_INDEX);

   bus_src_e src;

   always_comb begin
      if (ack)             src = BUS_INDEX;
      else if (drive_flag) src = BUS_FLAG;
      else                 src = BUS_IDLE;
   end

   always_comb begin
      data = '0;
      oe   = 1'b0;
      case (src)
         BUS_INDEX: begin
            data[IDX_W-1:0] = IDX_VAL;
            oe = 1'b1;
         end
         BUS_FLAG: begin
            data[0] = flag;
            oe = 1'b1;
         end
         default: begin
            data = '0;
            oe   = 1'b0;
         end
      endcase
   end

   initial begin
      assert (BUS_W >= IDX_W && IDX_W >= 1)
         else $error("irq_bus_drive: index field wider than bus");
      assert (DEV_INDEX >= 0 && DEV_INDEX < (1 << IDX_W))
         else $error("irq_bus_drive: DEV_INDEX does not fit IDX_W");
   end

   always_comb begin
      if (ack) assert_ack_index_R8: assert (oe && data == BUS_W'(DEV_INDEX));
      if (!ack && !drive_flag) assert_idle_R10: assert (!oe && data == '0);
   end

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
   parameter int BUS_W     = 32,
   parameter int IDX_W     = 4,
   parameter int DEV_INDEX = 1,
   parameter int REQ_MODE  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_req,
   input  logic             ien_load,
   input  logic             ien_drive,
   input  logic             ien_data,
   input  logic             int_ack,
   output logic             take_int,
   output logic             ien_flag,
   output logic             bus_oe,
   output logic [BUS_W-1:0] bus_data
);

   logic pend;

   irq_enable_reg u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ien_load),
      .data  (ien_data),
      .ack   (int_ack),
      .flag  (ien_flag)
   );

   irq_pending_latch #(.REQ_MODE(REQ_MODE)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (irq_req),
      .ack   (int_ack),
      .pend  (pend)
   );

   irq_bus_drive #(.BUS_W(BUS_W), .IDX_W(IDX_W), .DEV_INDEX(DEV_INDEX)) u_bus (
      .ack        (int_ack),
      .drive_flag (ien_drive),
      .flag       (ien_flag),
      .oe         (bus_oe),
      .data       (bus_data)
   );

   assign take_int = ien_flag & pend;

   assert_take_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> ien_flag);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!ien_flag && !take_int));

endmodule

// File: tb/tb_irq_gate.sv
`timescale 1ns/1ps
module tb_irq_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0, ien_load = 1'b0, ien_drive = 1'b0;
   logic        ien_data = 1'b0, int_ack = 1'b0;
   logic        take_int, ien_flag, bus_oe;
   logic [31:0] bus_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   bit m_en = 1'b0;
   bit m_pend = 1'b0;

   always #4 clk = ~clk;

   irq_gate dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ien_load(ien_load),
      .ien_drive(ien_drive), .ien_data(ien_data), .int_ack(int_ack),
      .take_int(take_int), .ien_flag(ien_flag), .bus_oe(bus_oe),
      .bus_data(bus_data)
   );

   function automatic logic [31:0] exp_bus(bit ack, bit drv, bit en);
      if (ack)      return 32'h0000_0001;
      else if (drv) return {31'b0, en};
      else          return 32'h0;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R2/R7 flag", {31'b0, ien_flag}, {31'b0, m_en});
      chk("R3/R4 take_int", {31'b0, take_int}, {31'b0, m_en & m_pend});
      chk("R8/R9/R10 bus_oe", {31'b0, bus_oe}, {31'b0, int_ack | ien_drive});
      chk("R8/R9/R10 bus_data", bus_data, exp_bus(int_ack, ien_drive, m_en));
   endtask

   // one cycle: drive after negedge, check before posedge, update model at posedge
   task automatic step(bit rq, bit ld, bit d, bit drv, bit ack);
      @(negedge clk);
      irq_req = rq; ien_load = ld; ien_data = d; ien_drive = drv; int_ack = ack;
      #1 check_all();
      @(posedge clk);
      if (ack)     m_en = 1'b0;
      else if (ld) m_en = d;
      m_pend = rq | (m_pend & ~ack);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R1 flag in reset", {31'b0, ien_flag}, 32'h0);
      chk("R1 take_int in reset", {31'b0, take_int}, 32'h0);
      chk("R1 bus_oe in reset", {31'b0, bus_oe}, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 flag after reset", {31'b0, ien_flag}, 32'h0);
      chk("R1 take_int after reset", {31'b0, take_int}, 32'h0);

      // R3: pulse with flag off, hold many cycles, then enable
      step(1, 0, 0, 0, 0);
      repeat (5) step(0, 0, 0, 0, 0);
      step(0, 1, 1, 0, 0);
      #1 chk("R3 pending survives while disabled", {31'b0, take_int}, 32'h1);

      // R9: flag driven on bus
      step(0, 0, 0, 1, 0);

      // R7, R8: ack with simultaneous load 1 and drive; ack wins
      step(0, 1, 1, 1, 1);
      #1 chk("R7 ack clears flag over load", {31'b0, ien_flag}, 32'h0);
      // R5: pending cleared
      step(0, 1, 1, 0, 0);
      #1 chk("R5 ack cleared pending", {31'b0, take_int}, 32'h0);

      // R6: request collides with ack
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 1);
      step(0, 1, 1, 0, 0);
      #1 chk("R6 collision keeps request", {31'b0, take_int}, 32'h1);

      // R2: load writes 0, then hold
      step(0, 1, 0, 0, 0);
      #1 chk("R2 load writes 0", {31'b0, ien_flag}, 32'h0);
      step(0, 0, 1, 0, 0);
      #1 chk("R2 no load holds", {31'b0, ien_flag}, 32'h0);
      // R4: pending but disabled
      chk("R4 take_int low when disabled", {31'b0, take_int}, 32'h0);
      // R10: idle bus
      step(0, 0, 0, 0, 0);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         bit rq, ld, d, drv, ack;
         rq  = ($urandom % 8) == 0;
         ld  = ($urandom % 4) == 0;
         d   = $urandom % 2;
         drv = ($urandom % 4) == 0;
         ack = ($urandom % 6) == 0;
         step(rq, ld, d, drv, ack);
      end
      finish_run();
   end

endmodule